// File: doc/BRIEF.md
# Skip-Word Rate-Matching Elastic Buffer

This block sits in a serial receive path between a recovered write clock and the local read clock. Those two clocks are nominally equal but may drift apart by up to ±300 ppm. Each incoming 32-bit word carries four 8-bit symbols. An upstream block synchronizer raises `in_skip` on every word that belongs to a skip ordered set. A run of consecutive flagged words forms one ordered set. Words cross the clock boundary through a 16-entry dual-clock buffer. The write and read pointers are passed between the domains as Gray code through two-flop synchronizers.

The buffer does not stall the sender or simply report full and empty. Instead it steers its fill level toward the middle by changing only skip content, and each change is one whole word, that is, four skip symbols:
- When the write side sees the buffer nearly full, it discards one flagged skip word.
- When the read side sees the buffer nearly empty, it emits the first skip word of an ordered set twice.

Each change produces a one-cycle event pulse in the domain that made it. Payload words are never dropped or repeated by this mechanism. A real overflow or underflow raises a sticky flag that stays set until reset.

Top module: `skip_rate_elastic`

## Requirements
- R1: After reset, `out_valid`, `ins_evt`, `del_evt`, `wr_overflow` and `rd_underflow` are all 0.
- R2: Non-skip words leave on `out_data` in the order they were written, none lost and none repeated, while neither sticky flag is set.
- R3: Delete rule. When a valid skip word arrives and the write-side occupancy is at least HI_MARK (default 12), the word is not stored. `del_evt` is then high for one write-clock cycle, in the cycle after that write edge. At most one word is deleted per run of consecutive skip words.
- R4: Insert rule. The read side may insert only when three conditions hold:
  - the head word is a skip word;
  - the previous word output was not a skip word;
  - the read-side occupancy is at most LO_MARK (default 4).
  
  In that case the head word is output twice. `ins_evt` is high together with `out_valid` on the first copy, the second copy follows on the next read cycle, and `ins_evt` is never high on two consecutive cycles.
- R5: After reset, `out_valid` stays 0 until the read-side occupancy has reached START_FILL (default 8).
- R6: A valid non-skip word written while the buffer holds 16 entries is discarded, and `wr_overflow` becomes 1 on the next write cycle and stays 1 until reset.
- R7: After output has started, a read cycle that finds the buffer empty drives `out_valid` to 0 and sets `rd_underflow`, which stays 1 until reset.
- R8: A skip word arriving while the buffer is full is handled as a delete (R3) and does not set `wr_overflow`.
- R9: With the write clock faster than the read clock, or with the write stream thinned by idle cycles, and one skip ordered set of two words every eight words, the buffer runs with both sticky flags clear. Over that run, skip words out equal skip words in minus deletes plus inserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered write clock |
| wrst_n | input | 1 | Active-low asynchronous reset, write domain |
| in_data | input | 32 | Incoming word of four symbols |
| in_valid | input | 1 | `in_data` is valid this write cycle |
| in_skip | input | 1 | Word belongs to a skip ordered set |
| rclk | input | 1 | Local read clock |
| rrst_n | input | 1 | Active-low asynchronous reset, read domain |
| out_data | output | 32 | Outgoing word |
| out_valid | output | 1 | `out_data` holds a word this read cycle |
| ins_evt | output | 1 | One-cycle pulse: a skip word was inserted (read domain) |
| del_evt | output | 1 | One-cycle pulse: a skip word was deleted (write domain) |
| wr_overflow | output | 1 | Sticky: a payload word was lost to a full buffer |
| rd_underflow | output | 1 | Sticky: the read side found the buffer empty after start |

## Verification
On the write side, the delete decision and the full condition can land on the same clock edge. There, a skip word must be taken as a delete and must not be counted as an overflow.

The bench provokes this coincidence by holding the read domain in reset and writing sixteen payload words, then one skip word. It judges the result by looking for a `del_evt` pulse with `wr_overflow` still clear, followed by `wr_overflow` rising on the next payload word. In the read domain, the insert condition meeting a near-empty buffer is exercised by thinning the write stream, and each insert is judged by the doubled skip word that follows the pulse.

// File: rtl/sre_pkg.sv
`timescale 1ns/1ps
package sre_pkg;
  localparam int PW = 16;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/sre_sync.sv
`timescale 1ns/1ps
module sre_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sre_mem.sv
`timescale 1ns/1ps
module sre_mem #(
  parameter int W  = 33,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdin,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdout
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdin;
  end

  assign rdout = cells[raddr];
endmodule

// File: rtl/sre_wctrl.sv
`timescale 1ns/1ps
module sre_wctrl
  import sre_pkg::*;
#(
  parameter int AW = 4,
  parameter int HI = 12
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          in_valid,
  input  logic          in_skip,
  input  logic [AW:0]   rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          del_evt,
  output logic          overflow
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] HI_V   = (AW+1)'(HI);
  localparam logic [AW:0] FULL_V = (AW+1)'(DEPTH);

  logic [AW:0] wbin_q, wbin_nx, wgray_nx, rbin_s, occ;
  logic        in_run_q, in_run_nx, done_q, done_nx;
  logic        del_q, ovf_q, ovf_nx, full, done_cur, drop;
  logic [PW-1:0] rb_full;

  always_comb begin
    rb_full   = gray2bin(PW'(rgray_s));
    rbin_s    = rb_full[AW:0];
    occ       = wbin_q - rbin_s;
    full      = (occ == FULL_V);
    done_cur  = in_run_q & done_q;
    drop      = in_valid & in_skip & (occ >= HI_V) & ~done_cur;
    we        = in_valid & ~drop & ~full;
    ovf_nx    = ovf_q | (in_valid & ~drop & full);
    wbin_nx   = wbin_q + (AW+1)'(we);
    wgray_nx  = bin2gray(PW'(wbin_nx))[AW:0];
    in_run_nx = in_valid ? in_skip : in_run_q;
    done_nx   = in_valid ? (in_skip & (done_cur | drop)) : done_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q   <= '0;
      wgray    <= '0;
      in_run_q <= 1'b0;
      done_q   <= 1'b0;
      del_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      wbin_q   <= wbin_nx;
      wgray    <= wgray_nx;
      in_run_q <= in_run_nx;
      done_q   <= done_nx;
      del_q    <= drop;
      ovf_q    <= ovf_nx;
    end
  end

  assign waddr    = wbin_q[AW-1:0];
  assign del_evt  = del_q;
  assign overflow = ovf_q;

  // R3: one delete per skip run, so never two pulses back to back
  p_one_delete_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    del_evt |=> !del_evt);
  // R6: payload at full is lost and flagged
  p_full_payload_ovf_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
    (in_valid && !in_skip && full) |=> overflow);
  // R6: the flag is sticky
  p_ovf_sticky_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
    overflow |=> overflow);
  // R8: first skip of a run at full is a delete, not an overflow
  p_skip_full_no_ovf_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    (in_valid && in_skip && full && !overflow && !done_cur) |=> (!overflow && del_evt));
endmodule

// File: rtl/sre_rctrl.sv
`timescale 1ns/1ps
module sre_rctrl
  import sre_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int LO    = 4,
  parameter int START = 8
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [AW:0]   wgray_s,
  input  logic [DW:0]   head,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          ins_evt,
  output logic          underflow
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] LO_V = (AW+1)'(LO);
  localparam logic [AW:0] ST_V = (AW+1)'(START);

  logic [AW:0]   rbin_q, rbin_nx, rgray_nx, wbin_s, occ;
  logic [DW-1:0] data_q, data_nx;
  logic          primed_q, primed_nx, prev_skip_q, prev_skip_nx;
  logic          vld_nx, ins, pop, empty, udf_q, udf_nx, ins_q;
  logic [PW-1:0] wb_full;

  always_comb begin
    wb_full      = gray2bin(PW'(wgray_s));
    wbin_s       = wb_full[AW:0];
    occ          = wbin_s - rbin_q;
    empty        = (occ == '0);
    primed_nx    = primed_q | (occ >= ST_V);
    vld_nx       = primed_q & ~empty;
    ins          = vld_nx & head[DW] & ~prev_skip_q & (occ <= LO_V);
    pop          = vld_nx & ~ins;
    rbin_nx      = rbin_q + (AW+1)'(pop);
    rgray_nx     = bin2gray(PW'(rbin_nx))[AW:0];
    data_nx      = vld_nx ? head[DW-1:0] : data_q;
    prev_skip_nx = vld_nx ? head[DW] : prev_skip_q;
    udf_nx       = udf_q | (primed_q & empty);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q      <= '0;
      rgray       <= '0;
      data_q      <= '0;
      primed_q    <= 1'b0;
      prev_skip_q <= 1'b0;
      out_valid   <= 1'b0;
      ins_q       <= 1'b0;
      udf_q       <= 1'b0;
    end else begin
      rbin_q      <= rbin_nx;
      rgray       <= rgray_nx;
      data_q      <= data_nx;
      primed_q    <= primed_nx;
      prev_skip_q <= prev_skip_nx;
      out_valid   <= vld_nx;
      ins_q       <= ins;
      udf_q       <= udf_nx;
    end
  end

  assign raddr     = rbin_q[AW-1:0];
  assign out_data  = data_q;
  assign ins_evt   = ins_q;
  assign underflow = udf_q;

  // R4: an insert is never repeated on the next cycle
  p_no_double_insert_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    ins_evt |=> !ins_evt);
  // R4: the insert pulse comes with an output word
  p_insert_with_word_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    ins_evt |-> out_valid);
  // R5: no output before priming
  p_quiet_until_primed_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    !primed_q |=> !out_valid);
  // R7: underflow flag is sticky
  p_udf_sticky_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    underflow |=> underflow);
  // R2: the read side never sees more entries than exist
  p_occ_bound_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    occ <= (AW+1)'(DEPTH));
endmodule

// File: rtl/skip_rate_elastic.sv
`timescale 1ns/1ps
module skip_rate_elastic #(
  parameter int DW         = 32,
  parameter int AW         = 4,
  parameter int HI_MARK    = (1 << AW) - 4,
  parameter int LO_MARK    = 4,
  parameter int START_FILL = (1 << AW) / 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_skip,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          ins_evt,
  output logic          del_evt,
  output logic          wr_overflow,
  output logic          rd_underflow
);
  localparam int EW = DW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [EW-1:0] head;

  sre_mem #(.W(EW), .AW(AW)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdin({in_skip, in_data}),
    .raddr(raddr), .rdout(head)
  );

  sre_sync #(.W(AW+1)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
  );

  sre_sync #(.W(AW+1)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
  );

  sre_wctrl #(.AW(AW), .HI(HI_MARK)) u_wctrl (
    .wclk(wclk), .wrst_n(wrst_n), .in_valid(in_valid), .in_skip(in_skip),
    .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
    .del_evt(del_evt), .overflow(wr_overflow)
  );

  sre_rctrl #(.DW(DW), .AW(AW), .LO(LO_MARK), .START(START_FILL)) u_rctrl (
    .rclk(rclk), .rrst_n(rrst_n), .wgray_s(wgray_s), .head(head),
    .raddr(raddr), .rgray(rgray), .out_data(out_data), .out_valid(out_valid),
    .ins_evt(ins_evt), .underflow(rd_underflow)
  );
endmodule

// File: tb/tb_skip_rate_elastic.sv
`timescale 1ns/1ps
module tb_skip_rate_elastic;
  localparam logic [31:0] SKIPW = 32'h1C1C1C1C;

  logic wclk = 1'b0, rclk = 1'b0, wrst_n = 1'b0, rrst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic in_valid = 1'b0, in_skip = 1'b0;
  logic [31:0] out_data;
  logic out_valid, ins_evt, del_evt, wr_overflow, rd_underflow;

  always #2.5 wclk = ~wclk;
  always #2.6 rclk = ~rclk;

  skip_rate_elastic dut (
    .wclk(wclk), .wrst_n(wrst_n), .in_data(in_data), .in_valid(in_valid),
    .in_skip(in_skip), .rclk(rclk), .rrst_n(rrst_n), .out_data(out_data),
    .out_valid(out_valid), .ins_evt(ins_evt), .del_evt(del_evt),
    .wr_overflow(wr_overflow), .rd_underflow(rd_underflow)
  );

  int checks = 0, failures = 0;
  logic [31:0] sb[$];
  int skips_in = 0, skips_out = 0, dels = 0, inss = 0, early = 0;
  int seq = 0, wd = 0;
  bit mon_en = 0, priming = 0, dup_pending = 0, last_out_skip = 0;
  bit used_skip = 0, used_valid = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: inputs change 1 ns after the write edge; the word just consumed is recorded.
  task automatic put(input logic [31:0] d, input bit sk);
    @(posedge wclk); #1;
    used_skip = in_skip; used_valid = in_valid;
    in_data = d; in_skip = sk; in_valid = 1'b1;
    if (mon_en) begin
      if (sk) skips_in++;
      else sb.push_back(d);
    end
  endtask

  task automatic idle();
    @(posedge wclk); #1;
    used_skip = in_skip; used_valid = in_valid;
    in_valid = 1'b0; in_skip = 1'b0;
  endtask

  task automatic put_data();
    seq++;
    put(32'hD000_0000 + 32'(seq), 1'b0);
  endtask

  // Write-side monitor: R3 delete pulses follow only a consumed skip word
  always @(negedge wclk) begin
    if (mon_en && del_evt) begin
      dels++;
      chk(used_valid && used_skip, "R3 delete follows a skip word", 32'(used_skip), 1);
    end
  end

  // Read-side scoreboard monitor
  always @(negedge rclk) begin
    if (mon_en) begin
      if (priming && out_valid) early++;
      if (dup_pending) begin
        chk(out_valid && out_data == SKIPW, "R4 second copy of inserted skip", out_data, SKIPW);
        dup_pending = 0;
      end
      if (ins_evt) begin
        inss++;
        chk(out_valid && out_data == SKIPW && !last_out_skip, "R4 insert at set start",
            out_data, SKIPW);
        dup_pending = 1;
      end
      if (out_valid) begin
        if (out_data == SKIPW) begin
          skips_out++;
          last_out_skip = 1;
        end else begin
          last_out_skip = 0;
          if (sb.size() == 0) chk(0, "R2 unexpected payload word", out_data, 0);
          else begin
            logic [31:0] e;
            e = sb.pop_front();
            chk(out_data == e, "R2 payload order", out_data, e);
          end
        end
      end
    end
  end

  always @(posedge wclk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #12;
    chk(!out_valid && !ins_evt && !del_evt && !wr_overflow && !rd_underflow,
        "R1 reset outputs", {out_valid, ins_evt, del_evt, wr_overflow, rd_underflow}, 0);

    // R8/R6: read domain held in reset, write side fills to 16
    wrst_n = 1'b1;
    for (int i = 0; i < 16; i++) put_data();
    put(SKIPW, 1'b1);
    idle();
    chk(del_evt == 1'b1, "R8 skip at full is deleted", del_evt, 1);
    chk(wr_overflow == 1'b0, "R8 no overflow on skip at full", wr_overflow, 0);
    put_data();
    idle();
    chk(wr_overflow == 1'b1, "R6 payload at full sets overflow", wr_overflow, 1);
    repeat (5) idle();
    chk(wr_overflow == 1'b1, "R6 overflow sticky", wr_overflow, 1);

    // Fresh start for the streaming phases
    wrst_n = 1'b0; #7; wrst_n = 1'b1; rrst_n = 1'b1;
    mon_en = 1; priming = 1;
    for (int i = 0; i < 7; i++) put_data();
    idle();
    repeat (20) idle();
    chk(early == 0, "R5 quiet below start fill", early, 0);
    priming = 0;

    // R9 phase 1: write every cycle, faster write clock -> deletes
    for (int b = 0; b < 80; b++) begin
      put(SKIPW, 1'b1); put(SKIPW, 1'b1);
      for (int k = 0; k < 6; k++) put_data();
    end
    chk(dels > 0, "R3 deletes occur when filling", dels, 1);
    chk(!wr_overflow && !rd_underflow, "R9 no error under fast writer",
        {wr_overflow, rd_underflow}, 0);

    // R9 phase 2: one idle per eight write cycles -> inserts
    for (int b = 0; b < 80; b++) begin
      put(SKIPW, 1'b1); put(SKIPW, 1'b1);
      for (int k = 0; k < 5; k++) put_data();
      idle();
      put_data();
    end
    idle();
    chk(inss > 0, "R4 inserts occur when draining", inss, 1);
    chk(!wr_overflow && !rd_underflow, "R9 no error under slow writer",
        {wr_overflow, rd_underflow}, 0);

    // R7: stop writing, buffer runs dry
    repeat (80) idle();
    chk(sb.size() == 0, "R2 all payload delivered", sb.size(), 0);
    chk(skips_out == skips_in - dels + inss, "R9 skip balance", skips_out,
        skips_in - dels + inss);
    chk(rd_underflow == 1'b1, "R7 underflow flag set", rd_underflow, 1);
    chk(out_valid == 1'b0, "R7 no valid when empty", out_valid, 0);
    chk(wr_overflow == 1'b0, "R6 no overflow in normal run", wr_overflow, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule